// File: doc/BRIEF.md
# MII Collision and Carrier Sense Generator

This block drives the collision (`col`) and carrier sense (`crs`) outputs that a 10/100 Ethernet PHY presents to its MAC. It watches whether the transmit and receive channels are busy. It also takes a valid-data qualifier from the receive front end, an end-of-packet strobe, the link speed and duplex, a heartbeat enable and a one-cycle strobe that marks each 10 Mb/s bit time. Both outputs are registered and change only on the rising edge of `clk`.

In half duplex, a collision means both channels are busy at once. At 100 Mb/s, and whenever the receive channel was busy first, the collision is reported at once. When a 10 Mb/s transmission runs into receive activity, `col` stays low until the overlap has lasted seven bit-time strobes. This keeps line noise from being reported as a collision. After each 10 Mb/s transmission, and only when heartbeat is enabled, the block waits a fixed number of bit times and then raises a signal-quality pulse of fixed width on `col`. `crs` follows receive carrier in either duplex, and also follows transmit activity in half duplex.

The receive carrier is latched when valid data is seen and is held until the end-of-packet strobe. Squelch, signal detect and symbol decoding happen upstream and reach this block only as the `rx_dvalid` and `rx_busy` qualifiers.

Top module: `mii_colcrs_gen`

## Requirements
- R1: While `rst` is sampled high, and on the first edge after it is released, `col` and `crs` are 0.
- R2: When `full_dpx`=1 is sampled, `col` is 0 after that edge, even after a heartbeat-enabled transmission ends.
- R3: In half duplex (`full_dpx`=0) with `spd_100`=1, `col` is 1 on the edge that samples `tx_busy`=1 and `rx_busy`=1 together.
- R4: In half duplex at 10 Mb/s (`spd_100`=0), when transmit became busy no later than receive, `col` stays 0 through the first six `bit_tick` strobes of the overlap. It goes to 1 on the edge that samples the seventh strobe and stays 1 while the overlap lasts.
- R5: The 10 Mb/s qualification count restarts from zero whenever either channel is sampled idle. An overlap that is interrupted needs seven fresh strobes.
- R6: In half duplex at 10 Mb/s, when `rx_busy` was sampled 1 with `tx_busy`=0 on an earlier edge of the same receive activity, `col` is 1 on the first edge that samples both busy.
- R7: `col` is 0 on the edge after the overlap ends, unless a heartbeat pulse is due.
- R8: With `sqe_en`=1, `spd_100`=0 and `full_dpx`=0, a falling `tx_busy` arms a heartbeat. Counting the strobes after the fall, `col` is 1 after the edges that sample strobes 10 through 19 and is 0 from the 20th on. With `sqe_en`=0 or `spd_100`=1, no pulse appears.
- R9: `tx_busy` sampled 1 cancels a pending or running heartbeat. The next fall re-arms it from zero.
- R10: In half duplex, `crs` is 1 on the edge after `tx_busy`=1 or a latched receive carrier. In full duplex, only the latched receive carrier sets it.
- R11: The receive carrier latches when `rx_dvalid`=1 is sampled and holds while `rx_dvalid` drops, until `rx_eop`=1 is sampled. When both are 1 on the same edge, `rx_eop` wins and the carrier is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_busy | input | 1 | Transmit channel busy |
| rx_busy | input | 1 | Receive channel busy on the line |
| rx_dvalid | input | 1 | Receive path has detected valid data |
| rx_eop | input | 1 | One-cycle end-of-packet strobe from the receive path |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dpx | input | 1 | 1 = full duplex, 0 = half duplex |
| sqe_en | input | 1 | Heartbeat (SQE test) enable |
| bit_tick | input | 1 | One-cycle strobe per 10 Mb/s bit time |
| col | output | 1 | Collision indication, registered |
| crs | output | 1 | Carrier sense, registered |

## Verification
The bench builds the block with its default parameters: a qualification length of seven strobes, and a heartbeat delay and width of ten strobes each. These values are small enough that every collision and heartbeat case can be walked strobe by strobe. The bench sweeps all combinations of speed and duplex for the collision checks, and all combinations of speed, duplex and heartbeat enable for the heartbeat checks. For each one it computes the expected `col` from the strobe count alone. Interrupted overlaps, receive-led collisions, heartbeat cancellation and the carrier latch with its end-of-packet priority are each driven as separate scenarios.

// File: rtl/miicc_pkg.sv
package miicc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_PULSE = 2'd2
  } sqe_state_e;
endpackage

// File: rtl/miicc_coll_qual.sv
module miicc_coll_qual #(
  parameter int QUAL_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic spd_100,
  input  logic full_dpx,
  input  logic bit_tick,
  output logic coll_hit
);
  localparam int CW = $clog2(QUAL_BITS + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_BITS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lead_q;
  logic          overlap;

  assign overlap = !full_dpx && tx_busy && rx_busy;

  // bit strobes counted while the overlap lasts, saturating at the limit
  always_comb begin
    if (!overlap)
      cnt_d = '0;
    else if (bit_tick && (cnt_q != QMAX))
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  // receive-led: receive was busy before transmit started
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lead_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lead_q <= rx_busy && (lead_q || !tx_busy);
    end
  end

  assign coll_hit = overlap && (spd_100 || lead_q || (cnt_d == QMAX));
endmodule

// File: rtl/miicc_sqe_gen.sv
module miicc_sqe_gen
  import miicc_pkg::*;
#(
  parameter int SQE_DLY = 10,
  parameter int SQE_WID = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic spd_100,
  input  logic full_dpx,
  input  logic sqe_en,
  input  logic bit_tick,
  output logic sqe_next
);
  localparam int MAXC = (SQE_DLY > SQE_WID) ? SQE_DLY : SQE_WID;
  localparam int TW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [TW-1:0] DLY_LAST = TW'(SQE_DLY - 1);
  localparam logic [TW-1:0] WID_LAST = TW'(SQE_WID - 1);

  sqe_state_e    st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;
  logic          tx_prev;

  always_comb begin
    st_d = st_q;
    tc_d = tc_q;
    if (tx_busy) begin
      st_d = SQ_IDLE;
      tc_d = '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (tx_prev && sqe_en && !spd_100 && !full_dpx) begin
            st_d = SQ_WAIT;
            tc_d = '0;
          end
        end
        SQ_WAIT: begin
          if (bit_tick) begin
            if (tc_q == DLY_LAST) begin
              st_d = SQ_PULSE;
              tc_d = '0;
            end else begin
              tc_d = tc_q + 1'b1;
            end
          end
        end
        SQ_PULSE: begin
          if (bit_tick) begin
            if (tc_q == WID_LAST) begin
              st_d = SQ_IDLE;
              tc_d = '0;
            end else begin
              tc_d = tc_q + 1'b1;
            end
          end
        end
        default: begin
          st_d = SQ_IDLE;
          tc_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      tc_q    <= '0;
      tx_prev <= 1'b0;
    end else begin
      st_q    <= st_d;
      tc_q    <= tc_d;
      tx_prev <= tx_busy;
    end
  end

  assign sqe_next = (st_d == SQ_PULSE) && sqe_en && !spd_100;
endmodule

// File: rtl/miicc_crs_gen.sv
module miicc_crs_gen (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic rx_dvalid,
  input  logic rx_eop,
  input  logic full_dpx,
  output logic crs_next
);
  logic car_q, car_d;

  // end of packet takes priority over a new valid-data indication
  always_comb begin
    if (rx_eop)
      car_d = 1'b0;
    else
      car_d = car_q || rx_dvalid;
  end

  always_ff @(posedge clk) begin
    if (rst)
      car_q <= 1'b0;
    else
      car_q <= car_d;
  end

  assign crs_next = car_d || (!full_dpx && tx_busy);
endmodule

// File: rtl/mii_colcrs_gen.sv
module mii_colcrs_gen #(
  parameter int QUAL_BITS = 7,
  parameter int SQE_DLY   = 10,
  parameter int SQE_WID   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic rx_dvalid,
  input  logic rx_eop,
  input  logic spd_100,
  input  logic full_dpx,
  input  logic sqe_en,
  input  logic bit_tick,
  output logic col,
  output logic crs
);
  logic coll_hit, sqe_next, crs_next;

  miicc_coll_qual #(.QUAL_BITS(QUAL_BITS)) u_qual (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .spd_100(spd_100), .full_dpx(full_dpx), .bit_tick(bit_tick),
    .coll_hit(coll_hit)
  );

  miicc_sqe_gen #(.SQE_DLY(SQE_DLY), .SQE_WID(SQE_WID)) u_sqe (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .spd_100(spd_100),
    .full_dpx(full_dpx), .sqe_en(sqe_en), .bit_tick(bit_tick),
    .sqe_next(sqe_next)
  );

  miicc_crs_gen u_crs (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_dvalid(rx_dvalid),
    .rx_eop(rx_eop), .full_dpx(full_dpx), .crs_next(crs_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= 1'b0;
      crs <= 1'b0;
    end else begin
      col <= !full_dpx && (coll_hit || sqe_next);
      crs <= crs_next;
    end
  end
endmodule

// File: rtl/miicc_checker.sv
module miicc_checker (
  input logic clk,
  input logic rst,
  input logic tx_busy,
  input logic rx_busy,
  input logic rx_eop,
  input logic spd_100,
  input logic full_dpx,
  input logic sqe_en,
  input logic col,
  input logic crs
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!col && !crs));

  // R2
  a_r2_no_col_full: assert property (@(posedge clk) disable iff (rst)
    full_dpx |=> !col);

  // R3
  a_r3_fast_coll: assert property (@(posedge clk) disable iff (rst)
    (spd_100 && !full_dpx && tx_busy && rx_busy) |=> col);

  // R7
  a_r7_col_drops: assert property (@(posedge clk) disable iff (rst)
    ((!tx_busy || !rx_busy) && (tx_busy || spd_100 || full_dpx || !sqe_en)) |=> !col);

  // R10
  a_r10_tx_crs_half: assert property (@(posedge clk) disable iff (rst)
    (!full_dpx && tx_busy) |=> crs);

  // R11
  a_r11_eop_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_eop && (full_dpx || !tx_busy)) |=> !crs);
endmodule

bind mii_colcrs_gen miicc_checker u_chk (
  .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_busy(rx_busy),
  .rx_eop(rx_eop), .spd_100(spd_100), .full_dpx(full_dpx),
  .sqe_en(sqe_en), .col(col), .crs(crs)
);

// File: tb/mii_colcrs_gen_test.sv
module mii_colcrs_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_busy = 0, rx_busy = 0, rx_dvalid = 0, rx_eop = 0;
  logic spd_100 = 0, full_dpx = 0, sqe_en = 0, bit_tick = 0;
  logic col, crs;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  mii_colcrs_gen uut (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .rx_dvalid(rx_dvalid), .rx_eop(rx_eop), .spd_100(spd_100),
    .full_dpx(full_dpx), .sqe_en(sqe_en), .bit_tick(bit_tick),
    .col(col), .crs(crs)
  );

  // inputs change at the falling edge; outputs are read at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_all();
    tx_busy = 0; rx_busy = 0; rx_dvalid = 0; rx_eop = 1; sqe_en = 0;
    step();
    rx_eop = 0;
    step();
  endtask

  initial begin
    step(); step(); step();
    chk("R1 col", col, 1'b0);
    chk("R1 crs", crs, 1'b0);
    rst = 0;
    step();
    chk("R1 col after release", col, 1'b0);
    chk("R1 crs after release", crs, 1'b0);

    // transmit-led overlap across all speed/duplex combinations
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 2; s++) begin
        full_dpx = f[0]; spd_100 = s[0];
        tx_busy = 1; step();
        rx_busy = 1; step();
        chk("R2/R3/R4 start", col, !f[0] && s[0]);
        chk("R10 tx crs", crs, !f[0]);
        for (int k = 1; k <= 9; k++) begin
          tick();
          chk("R2/R3/R4 strobe", col, !f[0] && (s[0] || k >= 7));
        end
        rx_busy = 0; step();
        chk("R7 overlap ends", col, 1'b0);
        tx_busy = 0; step();
        idle_all();
      end
    end

    // interrupted overlap restarts qualification
    full_dpx = 0; spd_100 = 0;
    tx_busy = 1; step();
    rx_busy = 1;
    for (int k = 0; k < 5; k++) tick();
    rx_busy = 0; step();
    rx_busy = 1; step();
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R5 restarted count", col, 1'b0);
    end
    tick();
    chk("R5 seventh fresh strobe", col, 1'b1);
    rx_busy = 0; tx_busy = 0; step();
    idle_all();

    // receive-led collision at 10 Mb/s
    rx_busy = 1; step();
    chk("R6 rx only", col, 1'b0);
    tx_busy = 1; step();
    chk("R6 immediate", col, 1'b1);
    rx_busy = 0; step();
    chk("R7 rx leaves", col, 1'b0);
    tx_busy = 0; step();
    idle_all();

    // heartbeat sweep
    for (int h = 0; h < 2; h++) begin
      for (int f = 0; f < 2; f++) begin
        for (int s = 0; s < 2; s++) begin
          sqe_en = h[0]; full_dpx = f[0]; spd_100 = s[0];
          tx_busy = 1; step();
          tx_busy = 0; step();
          chk("R8 after fall", col, 1'b0);
          for (int t = 1; t <= 22; t++) begin
            tick();
            chk("R8/R2 heartbeat", col,
                h[0] && !f[0] && !s[0] && (t >= 10) && (t < 20));
          end
          idle_all();
        end
      end
    end

    // cancellation by a new transmission
    sqe_en = 1; full_dpx = 0; spd_100 = 0;
    tx_busy = 1; step();
    tx_busy = 0; step();
    for (int t = 0; t < 8; t++) tick();
    tx_busy = 1; step();
    tx_busy = 0; step();
    for (int t = 1; t <= 10; t++) begin
      tick();
      chk("R9 re-armed", col, t >= 10);
    end
    idle_all();

    // carrier sense
    for (int f = 0; f < 2; f++) begin
      full_dpx = f[0];
      tx_busy = 1; step();
      chk("R10 tx only", crs, !f[0]);
      tx_busy = 0; step();
      chk("R10 tx gone", crs, 1'b0);
      rx_dvalid = 1; step();
      chk("R10/R11 rx carrier", crs, 1'b1);
      rx_dvalid = 0; step();
      chk("R11 carrier held", crs, 1'b1);
      tx_busy = 1; rx_eop = 1; step();
      rx_eop = 0;
      chk("R10/R11 eop with tx", crs, !f[0]);
      tx_busy = 0; step();
      chk("R11 cleared", crs, 1'b0);
      rx_dvalid = 1; rx_eop = 1; step();
      chk("R11 eop wins", crs, 1'b0);
      rx_dvalid = 0; rx_eop = 0; step();
      chk("R11 stays clear", crs, 1'b0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule